// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external 512K x 8 asynchronous static RAM. The host hands over one word at a time through a valid/ready handshake: a 19-bit address, a write flag and, for writes, an 8-bit data byte. The controller drives the memory's active-low chip enable, write enable and output enable, and its address bus. It handles the bidirectional data bus through separate out, in and drive-enable signals. For a read, it returns the fetched byte with a one-cycle valid pulse.

Every timing figure of the memory is a parameter in picoseconds. At elaboration, each one becomes a phase length in clock cycles by rounding up against the clock period, with at least one cycle per phase. A write has three phases. A set-up phase presents the address and data with write enable high. A strobe phase holds write enable low. A recovery phase raises write enable while the address and data stay put. A read is one access phase with chip enable and output enable low, followed by a turnaround gap in which nothing drives the bus. Between accesses the memory sits in standby with chip enable high.

With the default 20 ns clock, a write takes 1 + 3 + 1 cycles. A read takes 3 access cycles plus 1 turnaround cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: Whenever no access is in progress, mem_ce_n is 1 (standby), mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R3: A write (req_write=1) runs, starting the cycle after acceptance, for SETUP cycles with mem_ce_n=0 and mem_we_n=1. It then runs PULSE cycles with mem_we_n=0, where PULSE is at least ceil(tWP/Tclk), at least ceil(tDW/Tclk), and makes SETUP+PULSE at least ceil(tAW/Tclk). It ends with RECOV cycles of mem_we_n=1 and mem_ce_n=0, such that SETUP+PULSE+RECOV is at least ceil(tWC/Tclk).
- R4: While mem_ce_n stays 0, mem_addr holds the accepted address, and during a write mem_dq_o holds the accepted data.
- R5: During every write phase mem_oe_n is 1 and mem_dq_oe is 1, so the controller drives the bus.
- R6: A read (req_write=0) holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for ACC cycles, starting the cycle after acceptance. ACC is the largest of ceil(tRC/Tclk), ceil(tAA/Tclk) and ceil(tOE/Tclk).
- R7: mem_dq_i is captured on the clock edge that ends the read access. rsp_valid is 1 for exactly the following cycle, carrying that byte on rsp_rdata, in the same cycle that mem_ce_n and mem_oe_n return to 1.
- R8: After a read, TURN = ceil(tHZ/Tclk) cycles pass with mem_ce_n=1, mem_oe_n=1, mem_dq_oe=0 and req_ready=0 before the next request can be accepted.
- R9: req_ready is 0 from the cycle after acceptance until the access and any turnaround have finished. Only a request seen with req_ready=1 starts an access.
- R10: Each phase lasts at least one cycle even when its timing figure is zero. With the default zero address set-up time, the write set-up phase is exactly one cycle.
- R11: mem_we_n and mem_oe_n are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 19 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_i | input | 8 | Data received from the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |

## Verification
The checker watches several pin rules on every cycle:
- the address stays stable while the chip is selected;
- output enable and write enable are never low together, and output enable is high with the bus driven throughout each strobe;
- every write-enable pulse is at least PULSE cycles long;
- the bus drive never starts before output enable has been high for TURN cycles;
- ready is low while the chip is selected;
- the valid pulse follows the capture event.

Only the bench's scenarios can show the rest. They check the exact phase ordering and lengths against a model built from the timing figures. They check that written bytes land at the right address in the memory model. They also cover reads of unwritten and boundary addresses and read data returned after write-to-read and read-to-write sequences.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WSETUP  = 3'd1,
    PH_WSTROBE = 3'd2,
    PH_WRECOV  = 3'd3,
    PH_RACCESS = 3'd4,
    PH_RTURN   = 3'd5
  } phase_e;

  // Round a time up to whole clock cycles, never below one cycle.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned q;
    q = (t_ps + clk_ps - 1) / clk_ps;
    if (q < 1) q = 1;
    return q;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Strobe length: pulse width, data set-up, and address-valid-to-end-of-write.
  function automatic int unsigned strobe_len(input int unsigned wp, input int unsigned dw,
                                             input int unsigned aw, input int unsigned setup);
    int unsigned s;
    s = max_u(wp, dw);
    if (aw > setup) s = max_u(s, aw - setup);
    return s;
  endfunction

  // Recovery pads the write cycle to its minimum length, at least one cycle.
  function automatic int unsigned recov_len(input int unsigned wc, input int unsigned setup,
                                            input int unsigned strobe);
    return (wc > setup + strobe + 1) ? (wc - setup - strobe) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned RECOV_CYC  = 1,
  parameter int unsigned ACC_CYC    = 3,
  parameter int unsigned TURN_CYC   = 1,
  parameter int unsigned CNT_W      = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_e ph,
  output phase_e ph_nxt,
  output logic   accept,
  output logic   phase_end
);
  phase_e ph_q;
  logic   tmr_load;
  logic [CNT_W-1:0] tmr_val;

  function automatic logic [CNT_W-1:0] len_m1(input phase_e p);
    case (p)
      PH_WSETUP:  return CNT_W'(SETUP_CYC - 1);
      PH_WSTROBE: return CNT_W'(STROBE_CYC - 1);
      PH_WRECOV:  return CNT_W'(RECOV_CYC - 1);
      PH_RACCESS: return CNT_W'(ACC_CYC - 1);
      PH_RTURN:   return CNT_W'(TURN_CYC - 1);
      default:    return '0;
    endcase
  endfunction

  assign accept = (ph_q == PH_IDLE) && req_valid;

  always_comb begin
    ph_nxt = ph_q;
    case (ph_q)
      PH_IDLE:    if (req_valid) ph_nxt = req_write ? PH_WSETUP : PH_RACCESS;
      PH_WSETUP:  if (phase_end) ph_nxt = PH_WSTROBE;
      PH_WSTROBE: if (phase_end) ph_nxt = PH_WRECOV;
      PH_WRECOV:  if (phase_end) ph_nxt = PH_IDLE;
      PH_RACCESS: if (phase_end) ph_nxt = PH_RTURN;
      PH_RTURN:   if (phase_end) ph_nxt = PH_IDLE;
      default:    ph_nxt = PH_IDLE;
    endcase
  end

  assign tmr_load = (ph_nxt != ph_q);
  assign tmr_val  = len_m1(ph_nxt);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (phase_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_nxt;
  end

  assign ph = ph_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_PS  = 20000,
  parameter int unsigned T_RC_PS = 55000,
  parameter int unsigned T_AA_PS = 55000,
  parameter int unsigned T_OE_PS = 30000,
  parameter int unsigned T_HZ_PS = 20000,
  parameter int unsigned T_WC_PS = 55000,
  parameter int unsigned T_AW_PS = 50000,
  parameter int unsigned T_WP_PS = 45000,
  parameter int unsigned T_DW_PS = 25000,
  parameter int unsigned T_AS_PS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);
  localparam int unsigned SETUP_CYC  = ps_to_cyc(T_AS_PS, CLK_PS);
  localparam int unsigned STROBE_CYC = strobe_len(ps_to_cyc(T_WP_PS, CLK_PS),
                                                  ps_to_cyc(T_DW_PS, CLK_PS),
                                                  ps_to_cyc(T_AW_PS, CLK_PS), SETUP_CYC);
  localparam int unsigned RECOV_CYC  = recov_len(ps_to_cyc(T_WC_PS, CLK_PS), SETUP_CYC, STROBE_CYC);
  localparam int unsigned ACC_CYC    = max_u(max_u(ps_to_cyc(T_RC_PS, CLK_PS),
                                                   ps_to_cyc(T_AA_PS, CLK_PS)),
                                             ps_to_cyc(T_OE_PS, CLK_PS));
  localparam int unsigned TURN_CYC   = ps_to_cyc(T_HZ_PS, CLK_PS);
  localparam int unsigned MAX_CYC    = max_u(max_u(max_u(SETUP_CYC, STROBE_CYC),
                                                   max_u(RECOV_CYC, ACC_CYC)), TURN_CYC);
  localparam int unsigned CNT_W      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  phase_e ph, ph_nxt;
  logic   accept, phase_end, sample_evt;
  logic   nxt_sel, nxt_wr;

  sram_ctrl_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .RECOV_CYC  (RECOV_CYC),
    .ACC_CYC    (ACC_CYC),
    .TURN_CYC   (TURN_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ph        (ph),
    .ph_nxt    (ph_nxt),
    .accept    (accept),
    .phase_end (phase_end)
  );

  // Named events for the checker.
  assign sample_evt = (ph == PH_RACCESS) && phase_end;
  assign nxt_wr     = (ph_nxt == PH_WSETUP) || (ph_nxt == PH_WSTROBE) || (ph_nxt == PH_WRECOV);
  assign nxt_sel    = nxt_wr || (ph_nxt == PH_RACCESS);
  assign req_ready  = (ph == PH_IDLE);

  // Memory pins come straight from flops, set from the next phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
    end else begin
      mem_ce_n  <= !nxt_sel;
      mem_we_n  <= (ph_nxt != PH_WSTROBE);
      mem_oe_n  <= (ph_nxt != PH_RACCESS);
      mem_dq_oe <= nxt_wr;
      if (accept) begin
        mem_addr <= req_addr;
        if (req_write) mem_dq_o <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sample_evt;
      if (sample_evt) rsp_rdata <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned TURN_CYC   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              accept,
  input logic              sample_evt
);
  logic [7:0] we_low_run, oe_high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_run  <= '0;
      oe_high_run <= 8'hFF;
    end else begin
      if (!mem_we_n) we_low_run <= (we_low_run == 8'hFF) ? we_low_run : we_low_run + 1'b1;
      else           we_low_run <= '0;
      if (mem_oe_n)  oe_high_run <= (oe_high_run == 8'hFF) ? oe_high_run : oe_high_run + 1'b1;
      else           oe_high_run <= '0;
    end
  end

  p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_run >= STROBE_CYC));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

  p_read_nodrive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_ce_n));

  p_capture_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> (rsp_valid && mem_oe_n && mem_ce_n));

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_run >= TURN_CYC));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!req_ready && !mem_ce_n));

  p_sel_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  p_no_both_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STROBE_CYC (STROBE_CYC),
  .TURN_CYC   (TURN_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_o   (mem_dq_o),
  .accept     (accept),
  .sample_evt (sample_evt)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int CLK_PS = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = '0;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit mon_on = 1'b0;

  always #10ns clk = ~clk;

  sram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  // Phase lengths restated from the requirements (ceiling division, floor of 1).
  function automatic int up(input int t);
    int c;
    c = t / CLK_PS;
    if (c * CLK_PS < t) c++;
    return (c == 0) ? 1 : c;
  endfunction
  int n_setup, n_strobe, n_recov, n_acc, n_turn;
  initial begin
    n_setup  = up(0);
    n_strobe = up(45000);
    if (up(25000) > n_strobe) n_strobe = up(25000);
    if (up(50000) - n_setup > n_strobe) n_strobe = up(50000) - n_setup;
    n_recov  = up(55000) - n_setup - n_strobe;
    if (n_recov < 1) n_recov = 1;
    n_acc    = up(55000);
    if (up(30000) > n_acc) n_acc = up(30000);
    n_turn   = up(20000);
  end

  // Memory model and shadow contents.
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  function automatic logic [7:0] blank(input logic [18:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  always @(negedge clk)
    if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
      mem_dq_i <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : blank(mem_addr);
    else
      mem_dq_i <= 8'h00;
  always @(posedge mem_we_n)
    if (mem_ce_n === 1'b0 && rst_n) mem[int'(mem_addr)] = mem_dq_o;

  typedef struct {
    logic ce, we, oe, dqoe, rdy, rv;
    logic [18:0] a;
    logic [7:0]  d;
    bit chk_a, chk_d;
    string tag;
  } exp_t;
  exp_t q[$];

  function automatic exp_t mk(input logic ce, we, oe, dqoe, rdy, rv,
                              input logic [18:0] a, input logic [7:0] d,
                              input bit ca, cd, input string tag);
    exp_t e;
    e.ce = ce; e.we = we; e.oe = oe; e.dqoe = dqoe; e.rdy = rdy; e.rv = rv;
    e.a = a; e.d = d; e.chk_a = ca; e.chk_d = cd; e.tag = tag;
    return e;
  endfunction

  task automatic push_txn(input logic w, input logic [18:0] a, input logic [7:0] d);
    logic [7:0] rd;
    if (w) begin
      // R10: set-up phase is one cycle; R3/R4/R5 strobe shape with stable address and data.
      for (int i = 0; i < n_setup; i++)  q.push_back(mk(0,1,1,1,0,0,a,d,1,1,"R10"));
      for (int i = 0; i < n_strobe; i++) q.push_back(mk(0,0,1,1,0,0,a,d,1,1,"R3"));
      for (int i = 0; i < n_recov; i++)  q.push_back(mk(0,1,1,1,0,0,a,d,1,1,"R4"));
      shadow[int'(a)] = d;
    end else begin
      rd = shadow.exists(int'(a)) ? shadow[int'(a)] : blank(a);
      for (int i = 0; i < n_acc; i++)    q.push_back(mk(0,1,0,0,0,0,a,0,1,0,"R6"));
      // R7 valid pulse with data, R8 turnaround gap.
      for (int i = 0; i < n_turn; i++)   q.push_back(mk(1,1,1,0,0,(i == 0),a,rd,0,(i == 0),
                                                        (i == 0) ? "R7" : "R8"));
    end
  endtask

  // Reference comparison every cycle, sampled at the falling edge.
  always @(negedge clk) begin
    exp_t e;
    bit idle, bad;
    if (mon_on) begin
      idle = (q.size() == 0);
      e = idle ? mk(1,1,1,0,1,0,0,0,0,0,"R2") : q.pop_front();
      bad = (mem_ce_n !== e.ce) || (mem_we_n !== e.we) || (mem_oe_n !== e.oe) ||
            (mem_dq_oe !== e.dqoe) || (req_ready !== e.rdy) || (rsp_valid !== e.rv);
      if (e.chk_a && mem_addr !== e.a) bad = 1;
      if (e.chk_d && e.dqoe && mem_dq_o !== e.d) bad = 1;
      if (e.chk_d && e.rv && rsp_rdata !== e.d) bad = 1;
      if (!e.rdy && req_ready !== 1'b0) bad = 1;  // R9
      if (!mem_we_n && !mem_oe_n) bad = 1;        // R11
      n_tests++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s cyc %0d: ce/we/oe/oe_dq/rdy/rv=%b%b%b%b%b%b exp %b%b%b%b%b%b addr %h exp %h dq %h rdata %h exp %h",
                 e.tag, cyc, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid,
                 e.ce, e.we, e.oe, e.dqoe, e.rdy, e.rv, mem_addr, e.a, mem_dq_o, rsp_rdata, e.d);
      end
      if (idle && req_valid) push_txn(req_write, req_addr, req_wdata);
    end
  end

  task automatic do_req(input logic w, input logic [18:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (req_ready !== 1'b1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_write = ~w; req_addr = ~a; req_wdata = ~d;  // junk while busy: must be ignored (R9)
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: cycles %0d exp below 20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    n_tests++;
    if (mem_ce_n !== 1 || mem_we_n !== 1 || mem_oe_n !== 1 || mem_dq_oe !== 0 ||
        req_ready !== 1 || rsp_valid !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: ce/we/oe/oe_dq/rdy/rv=%b%b%b%b%b%b exp 111010",
               mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #1 mon_on = 1'b1;

    do_req(1, 19'h12345, 8'hA7);
    do_req(0, 19'h12345, 8'h00);
    do_req(0, 19'h00777, 8'h00);   // unwritten location
    do_req(1, 19'h00000, 8'h01);
    do_req(1, 19'h7FFFF, 8'hFE);   // back-to-back writes, boundary addresses
    do_req(0, 19'h7FFFF, 8'h00);
    do_req(0, 19'h00000, 8'h00);   // read then read
    do_req(1, 19'h00000, 8'h5A);   // read-to-write turnaround, overwrite
    do_req(0, 19'h00000, 8'h00);
    for (int i = 0; i < 8; i++) do_req(1, 19'(i * 4099), 8'(i * 37 + 3));
    for (int i = 7; i >= 0; i--) do_req(0, 19'(i * 4099), 8'h00);

    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule